// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Lockout

This block receives asynchronous serial frames on a single line. A tick that runs at sixteen times the bit rate comes from outside. The receiver waits for the line to go low while idle. It confirms the start bit near the middle of that bit, then samples each following bit at its midpoint. Data bits arrive least significant bit first, and a frame has 7 or 8 of them. An optional even or odd parity bit follows. The frame ends with one or two stop bits. The configuration inputs are captured when a start bit is accepted, so changing them during a frame does not affect that frame.

When the first stop bit has been sampled, three checks run in the same cycle. The first tests whether the holding register is still full. The second tests the parity, and the third tests whether the stop bit is high. If every check passes, the byte is copied to the holding register and the data-full flag is set. Each failure sets its own sticky flag instead, and the byte is not transferred. While any error flag is set, the receiver ignores the line completely. Software reads the byte with a read strobe and clears each error flag with its own strobe. One shared enable gates two level interrupt requests: one for data ready and one for any error.

Top module: `rxlock_top`

## Requirements
- R1: A low line seen while idle is accepted as a start bit only if the line is still low 8 ticks later. Otherwise the receiver returns to idle and no flag or data changes.
- R2: Data bits are assembled least significant bit first. In 7-bit mode `rxData[7]` reads 0 and bits 6:0 hold the received bits.
- R3: With parity enabled, a parity error is flagged when the number of ones in the data bits plus the parity bit is odd in even mode or even in odd mode (`cfgParityOdd`=1 selects odd). The flag is `errParity`.
- R4: A low first stop bit sets `errFraming`. In two-stop mode the second stop bit is never checked.
- R5: If `dataFull` is 1 when a frame is checked, `errOverrun` is set and `rxData` keeps the earlier byte.
- R6: Only a frame that passes all three checks sets `dataFull` and loads `rxData`.
- R7: While any error flag is set, arriving frames change neither `rxData`, `dataFull` nor any flag.
- R8: `rdStrobe` clears `dataFull`. `clrOverrun`, `clrParity` and `clrFraming` each clear only their own flag.
- R9: `irqRxData` equals `intEnable` AND `dataFull`. `irqRxErr` equals `intEnable` AND the OR of the three error flags.
- R10: Configuration inputs are sampled when a start bit is detected. Changing them during a frame has no effect on that frame.
- R11: After reset every flag, both interrupt requests and `rxData` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxLine | input | 1 | Serial input line, idles high |
| sampleTick | input | 1 | One-cycle pulse at 16x the bit rate |
| cfgSevenBits | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| cfgParityEn | input | 1 | 1 enables the parity bit |
| cfgParityOdd | input | 1 | 1 selects odd parity, 0 selects even |
| cfgTwoStop | input | 1 | 1 selects two stop bits |
| rdStrobe | input | 1 | Read of the holding register, clears dataFull |
| clrOverrun | input | 1 | Clears errOverrun |
| clrParity | input | 1 | Clears errParity |
| clrFraming | input | 1 | Clears errFraming |
| intEnable | input | 1 | Shared interrupt enable |
| rxData | output | 8 | Holding register |
| dataFull | output | 1 | Holding register contains an unread byte |
| errOverrun | output | 1 | Sticky overrun error |
| errParity | output | 1 | Sticky parity error |
| errFraming | output | 1 | Sticky framing error |
| irqRxData | output | 1 | Data-ready interrupt request |
| irqRxErr | output | 1 | Receive-error interrupt request |

## Verification
Frames are sent in 8-bit and 7-bit form, with no parity, even parity and odd parity, and with one or two stop bits. Asymmetric data values show whether the bit order is correct and whether bit 7 is masked. Corrupted parity bits and low stop bits are sent alone and together. Comparing the resulting flags shows that each check is independent and that only the first stop bit is tested. Other sequences cover a short low glitch, two frames with no read between them, good frames sent while an error is pending, and configuration changes made during a frame. These separate start qualification, overrun handling, lockout and configuration capture.

// File: rtl/rxlock_pkg.sv
package rxlock_pkg;

  typedef struct packed {
    logic sevenBits;
    logic parityEn;
    logic parityOdd;
    logic twoStop;
  } rxCfg_t;

  typedef struct packed {
    logic startFrame;
    logic shiftBit;
    logic capParity;
    logic checkFrame;
  } rxStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP1,
    ST_STOP2
  } rxState_t;

endpackage

// File: rtl/rxlock_ctrl.sv
module rxlock_ctrl
  import rxlock_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_MAX   = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sampleTick,
  input  logic      lineSync,
  input  logic      anyErr,
  input  rxCfg_t    cfgIn,
  output logic      cfgSeven,
  output logic      cfgParEn,
  output logic      cfgParOdd,
  output rxStrobe_t stb
);

  localparam int TICK_W = $clog2(OVERSAMPLE);
  localparam int BIT_W  = $clog2(DATA_MAX);

  rxState_t          state;
  logic [TICK_W-1:0] tickCnt;
  logic [BIT_W-1:0]  bitCnt;
  rxCfg_t            cfgQ;
  logic              fullTick;
  logic              halfTick;
  logic [BIT_W-1:0]  lastBit;

  assign fullTick = (tickCnt == TICK_W'(OVERSAMPLE - 1));
  assign halfTick = (tickCnt == TICK_W'(OVERSAMPLE / 2 - 1));
  assign lastBit  = cfgQ.sevenBits ? BIT_W'(DATA_MAX - 2) : BIT_W'(DATA_MAX - 1);

  assign cfgSeven  = cfgQ.sevenBits;
  assign cfgParEn  = cfgQ.parityEn;
  assign cfgParOdd = cfgQ.parityOdd;

  // Strobes to the datapath, each one clock wide on a sample tick
  always_comb begin
    stb            = '0;
    stb.startFrame = (state == ST_IDLE)   && sampleTick && !lineSync && !anyErr;
    stb.shiftBit   = (state == ST_DATA)   && sampleTick && fullTick;
    stb.capParity  = (state == ST_PARITY) && sampleTick && fullTick;
    stb.checkFrame = (state == ST_STOP1)  && sampleTick && fullTick;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
      cfgQ    <= '0;
    end else if (sampleTick) begin
      case (state)
        ST_IDLE: begin
          if (stb.startFrame) begin
            state   <= ST_START;
            tickCnt <= '0;
            cfgQ    <= cfgIn;
          end
        end
        ST_START: begin
          if (halfTick) begin
            tickCnt <= '0;
            bitCnt  <= '0;
            state   <= lineSync ? ST_IDLE : ST_DATA;
          end else begin
            tickCnt <= tickCnt + TICK_W'(1);
          end
        end
        ST_DATA: begin
          if (fullTick) begin
            tickCnt <= '0;
            if (bitCnt == lastBit) begin
              state <= cfgQ.parityEn ? ST_PARITY : ST_STOP1;
            end else begin
              bitCnt <= bitCnt + BIT_W'(1);
            end
          end else begin
            tickCnt <= tickCnt + TICK_W'(1);
          end
        end
        ST_PARITY: begin
          if (fullTick) begin
            tickCnt <= '0;
            state   <= ST_STOP1;
          end else begin
            tickCnt <= tickCnt + TICK_W'(1);
          end
        end
        ST_STOP1: begin
          if (fullTick) begin
            tickCnt <= '0;
            state   <= cfgQ.twoStop ? ST_STOP2 : ST_IDLE;
          end else begin
            tickCnt <= tickCnt + TICK_W'(1);
          end
        end
        ST_STOP2: begin
          if (fullTick) begin
            tickCnt <= '0;
            state   <= ST_IDLE;
          end else begin
            tickCnt <= tickCnt + TICK_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rxlock_dpath.sv
module rxlock_dpath
  import rxlock_pkg::*;
#(
  parameter int DATA_MAX = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rxLine,
  input  rxStrobe_t           stb,
  input  logic                cfgSeven,
  input  logic                cfgParEn,
  input  logic                cfgParOdd,
  input  logic                rdStrobe,
  input  logic                clrOverrun,
  input  logic                clrParity,
  input  logic                clrFraming,
  output logic                lineSync,
  output logic                anyErr,
  output logic [DATA_MAX-1:0] rxData,
  output logic                dataFull,
  output logic                errOverrun,
  output logic                errParity,
  output logic                errFraming
);

  logic [1:0]          syncReg;
  logic [DATA_MAX-1:0] shiftReg;
  logic [DATA_MAX-1:0] wordNow;
  logic                parBit;
  logic                parFail;
  logic                stopFail;

  assign lineSync = syncReg[1];
  assign anyErr   = errOverrun | errParity | errFraming;
  assign wordNow  = cfgSeven ? {1'b0, shiftReg[DATA_MAX-1:1]} : shiftReg;
  assign parFail  = cfgParEn && (^wordNow ^ parBit ^ cfgParOdd);
  assign stopFail = !lineSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncReg <= 2'b11;
    else       syncReg <= {syncReg[0], rxLine};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
    end else begin
      if (stb.shiftBit)  shiftReg <= {lineSync, shiftReg[DATA_MAX-1:1]};
      if (stb.capParity) parBit   <= lineSync;
    end
  end

  // Flags: a set from the frame check overrides a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData     <= '0;
      dataFull   <= 1'b0;
      errOverrun <= 1'b0;
      errParity  <= 1'b0;
      errFraming <= 1'b0;
    end else begin
      if (rdStrobe)   dataFull   <= 1'b0;
      if (clrOverrun) errOverrun <= 1'b0;
      if (clrParity)  errParity  <= 1'b0;
      if (clrFraming) errFraming <= 1'b0;
      if (stb.checkFrame) begin
        if (dataFull) errOverrun <= 1'b1;
        if (parFail)  errParity  <= 1'b1;
        if (stopFail) errFraming <= 1'b1;
        if (!dataFull && !parFail && !stopFail) begin
          dataFull <= 1'b1;
          rxData   <= wordNow;
        end
      end
    end
  end

endmodule

// File: rtl/rxlock_top.sv
module rxlock_top
  import rxlock_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_MAX   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rxLine,
  input  logic                sampleTick,
  input  logic                cfgSevenBits,
  input  logic                cfgParityEn,
  input  logic                cfgParityOdd,
  input  logic                cfgTwoStop,
  input  logic                rdStrobe,
  input  logic                clrOverrun,
  input  logic                clrParity,
  input  logic                clrFraming,
  input  logic                intEnable,
  output logic [DATA_MAX-1:0] rxData,
  output logic                dataFull,
  output logic                errOverrun,
  output logic                errParity,
  output logic                errFraming,
  output logic                irqRxData,
  output logic                irqRxErr
);

  rxStrobe_t stb;
  rxCfg_t    cfgIn;
  logic      lineSync;
  logic      anyErr;
  logic      cfgSeven;
  logic      cfgParEn;
  logic      cfgParOdd;

  assign cfgIn = '{sevenBits: cfgSevenBits, parityEn: cfgParityEn,
                   parityOdd: cfgParityOdd, twoStop: cfgTwoStop};

  rxlock_ctrl #(.OVERSAMPLE(OVERSAMPLE), .DATA_MAX(DATA_MAX)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sampleTick(sampleTick),
    .lineSync  (lineSync),
    .anyErr    (anyErr),
    .cfgIn     (cfgIn),
    .cfgSeven  (cfgSeven),
    .cfgParEn  (cfgParEn),
    .cfgParOdd (cfgParOdd),
    .stb       (stb)
  );

  rxlock_dpath #(.DATA_MAX(DATA_MAX)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .rxLine    (rxLine),
    .stb       (stb),
    .cfgSeven  (cfgSeven),
    .cfgParEn  (cfgParEn),
    .cfgParOdd (cfgParOdd),
    .rdStrobe  (rdStrobe),
    .clrOverrun(clrOverrun),
    .clrParity (clrParity),
    .clrFraming(clrFraming),
    .lineSync  (lineSync),
    .anyErr    (anyErr),
    .rxData    (rxData),
    .dataFull  (dataFull),
    .errOverrun(errOverrun),
    .errParity (errParity),
    .errFraming(errFraming)
  );

  assign irqRxData = intEnable & dataFull;
  assign irqRxErr  = intEnable & anyErr;

endmodule

// File: rtl/rxlock_chk.sv
module rxlock_chk #(
  parameter int DATA_MAX = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                rdStrobe,
  input logic                clrOverrun,
  input logic                intEnable,
  input logic [DATA_MAX-1:0] rxData,
  input logic                dataFull,
  input logic                errOverrun,
  input logic                errParity,
  input logic                errFraming,
  input logic                irqRxData,
  input logic                irqRxErr
);

  // R6: the holding register only fills when no error is present
  a_r6_clean_fill: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataFull) |-> !(errOverrun || errParity || errFraming));

  // R5: an unread byte is never overwritten
  a_r5_hold_unread: assert property (@(posedge clk) disable iff (!rstN)
    (dataFull && !rdStrobe) |=> $stable(rxData));

  // R7: no byte is accepted while an error is pending
  a_r7_lockout: assert property (@(posedge clk) disable iff (!rstN)
    (errOverrun || errParity || errFraming) |=> !$rose(dataFull));

  // R8: read and clear strobes take effect on the next cycle
  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && dataFull) |=> !dataFull);

  a_r8_ovr_clears: assert property (@(posedge clk) disable iff (!rstN)
    (clrOverrun && errOverrun) |=> !errOverrun);

  // R9: rising flags raise their request when enabled
  a_r9_data_irq: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(dataFull) && intEnable) |-> irqRxData);

  a_r9_err_irq: assert property (@(posedge clk) disable iff (!rstN)
    (($rose(errParity) || $rose(errFraming) || $rose(errOverrun)) && intEnable) |-> irqRxErr);

endmodule

bind rxlock_top rxlock_chk #(.DATA_MAX(DATA_MAX)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .rdStrobe  (rdStrobe),
  .clrOverrun(clrOverrun),
  .intEnable (intEnable),
  .rxData    (rxData),
  .dataFull  (dataFull),
  .errOverrun(errOverrun),
  .errParity (errParity),
  .errFraming(errFraming),
  .irqRxData (irqRxData),
  .irqRxErr  (irqRxErr)
);

// File: tb/test_rxlock_top.sv
`timescale 1ns/1ps
module test_rxlock_top;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rstN = 1'b0;
  logic       rxLine = 1'b1;
  logic       sampleTick = 1'b0;
  logic       cfgSevenBits = 1'b0, cfgParityEn = 1'b0, cfgParityOdd = 1'b0, cfgTwoStop = 1'b0;
  logic       rdStrobe = 1'b0, clrOverrun = 1'b0, clrParity = 1'b0, clrFraming = 1'b0;
  logic       intEnable = 1'b1;
  logic [7:0] rxData;
  logic       dataFull, errOverrun, errParity, errFraming, irqRxData, irqRxErr;

  rxlock_top i_rxlock_top (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .sampleTick(sampleTick),
    .cfgSevenBits(cfgSevenBits), .cfgParityEn(cfgParityEn),
    .cfgParityOdd(cfgParityOdd), .cfgTwoStop(cfgTwoStop),
    .rdStrobe(rdStrobe), .clrOverrun(clrOverrun), .clrParity(clrParity),
    .clrFraming(clrFraming), .intEnable(intEnable),
    .rxData(rxData), .dataFull(dataFull), .errOverrun(errOverrun),
    .errParity(errParity), .errFraming(errFraming),
    .irqRxData(irqRxData), .irqRxErr(irqRxErr)
  );

  // Reference state
  logic [7:0] mData = 8'h00;
  logic       mFull = 1'b0, mOvr = 1'b0, mPer = 1'b0, mFr = 1'b0;
  logic       valid = 1'b0;
  string      curReq = "R11";
  int         checks = 0;
  int         fails = 0;
  bit         done = 1'b0;

  // 16x tick: one cycle in four
  logic [1:0] tickDiv = 2'd0;
  always @(negedge clk) begin
    tickDiv    <= tickDiv + 2'd1;
    sampleTick <= (tickDiv == 2'd3);
  end

  task automatic cmp1(string name, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", curReq, name, act, exp, $time);
    end
  endtask

  // Compare every clock while the reference is in step with the design
  always @(negedge clk) begin
    if (valid && !done) begin
      cmp1("rxData", rxData, mData);
      cmp1("dataFull", dataFull, mFull);
      cmp1("errOverrun", errOverrun, mOvr);
      cmp1("errParity", errParity, mPer);
      cmp1("errFraming", errFraming, mFr);
      cmp1("irqRxData (R9)", irqRxData, intEnable & mFull);
      cmp1("irqRxErr (R9)", irqRxErr, intEnable & (mOvr | mPer | mFr));
    end
  end

  task automatic sendBit(input logic b);
    rxLine = b;
    repeat (64) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] d, input bit scramble, input bit flipPar,
                           input logic stop1, input logic stop2);
    logic s7, pe, po, ts;
    logic [7:0] mask;
    logic pbit;
    int n;
    s7 = cfgSevenBits; pe = cfgParityEn; po = cfgParityOdd; ts = cfgTwoStop;
    n = s7 ? 7 : 8;
    mask = s7 ? 8'h7F : 8'hFF;
    pbit = (^(d & mask)) ^ po ^ flipPar;
    valid = 1'b0;
    sendBit(1'b0);
    if (scramble) begin
      cfgSevenBits = ~s7; cfgParityEn = ~pe; cfgParityOdd = ~po; cfgTwoStop = ~ts;
    end
    for (int i = 0; i < n; i++) sendBit(d[i]);
    if (pe) sendBit(pbit);
    sendBit(stop1);
    if (ts) sendBit(stop2);
    cfgSevenBits = s7; cfgParityEn = pe; cfgParityOdd = po; cfgTwoStop = ts;
    rxLine = 1'b1;
    repeat (80) @(negedge clk);
    if (!(mOvr | mPer | mFr)) begin
      if (mFull || (pe && flipPar) || !stop1) begin
        mOvr = mOvr | mFull;
        mPer = mPer | (pe && flipPar);
        mFr  = mFr | !stop1;
      end else begin
        mFull = 1'b1;
        mData = d & mask;
      end
    end
    valid = 1'b1;
    repeat (16) @(negedge clk);
  endtask

  // which: 0 read, 1 overrun clear, 2 parity clear, 3 framing clear
  task automatic pulse(input int which);
    valid = 1'b0;
    case (which)
      0: rdStrobe = 1'b1;
      1: clrOverrun = 1'b1;
      2: clrParity = 1'b1;
      default: clrFraming = 1'b1;
    endcase
    @(negedge clk);
    rdStrobe = 1'b0; clrOverrun = 1'b0; clrParity = 1'b0; clrFraming = 1'b0;
    case (which)
      0: mFull = 1'b0;
      1: mOvr = 1'b0;
      2: mPer = 1'b0;
      default: mFr = 1'b0;
    endcase
    @(negedge clk);
    valid = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (10) @(negedge clk);
    rstN = 1'b1;
    // R11: reset state
    curReq = "R11";
    valid = 1'b1;
    repeat (20) @(negedge clk);

    // R2 / R6: 8-bit, no parity, one stop
    curReq = "R2 R6 8N1";
    sendFrame(8'hA5, 0, 0, 1, 1);
    curReq = "R8 read";
    pulse(0);
    curReq = "R2 8N1 asym";
    sendFrame(8'h1E, 0, 0, 1, 1);
    pulse(0);

    // R2: 7-bit mode, bit 7 masked
    cfgSevenBits = 1'b1;
    curReq = "R2 7N1";
    sendFrame(8'hD3, 0, 0, 1, 1);
    pulse(0);
    cfgSevenBits = 1'b0;

    // R3: even parity good and bad
    cfgParityEn = 1'b1; cfgParityOdd = 1'b0;
    curReq = "R3 even good";
    sendFrame(8'h3C, 0, 0, 1, 1);
    pulse(0);
    curReq = "R3 even bad";
    sendFrame(8'h3D, 0, 1, 1, 1);
    // R7: lockout while parity error pending
    curReq = "R7 lockout parity";
    sendFrame(8'h11, 0, 0, 1, 1);
    curReq = "R8 clear parity";
    pulse(2);

    // R3: odd parity good and bad
    cfgParityOdd = 1'b1;
    curReq = "R3 odd good";
    sendFrame(8'h07, 0, 0, 1, 1);
    pulse(0);
    curReq = "R3 odd bad";
    sendFrame(8'h80, 0, 1, 1, 1);
    pulse(2);

    // R4: framing with both parity and stop bad, separate clears
    curReq = "R4 R8 parity+framing";
    sendFrame(8'h55, 0, 1, 0, 1);
    pulse(2);
    curReq = "R8 framing remains";
    repeat (10) @(negedge clk);
    pulse(3);
    cfgParityEn = 1'b0; cfgParityOdd = 1'b0;

    // R4: single stop low, then second stop ignored
    curReq = "R4 stop low";
    sendFrame(8'h69, 0, 0, 0, 1);
    pulse(3);
    cfgTwoStop = 1'b1;
    curReq = "R4 second stop unchecked";
    sendFrame(8'h96, 0, 0, 1, 0);
    pulse(0);
    cfgTwoStop = 1'b0;

    // R5: overrun keeps first byte
    curReq = "R5 first";
    sendFrame(8'h21, 0, 0, 1, 1);
    curReq = "R5 overrun";
    sendFrame(8'h42, 0, 0, 1, 1);
    // R9: interrupts masked
    curReq = "R9 masked";
    intEnable = 1'b0;
    repeat (20) @(negedge clk);
    intEnable = 1'b1;
    curReq = "R7 read during lockout";
    pulse(0);
    curReq = "R7 lockout overrun";
    sendFrame(8'h99, 0, 0, 1, 1);
    curReq = "R8 clear overrun";
    pulse(1);
    curReq = "R6 after clear";
    sendFrame(8'h99, 0, 0, 1, 1);
    pulse(0);

    // R1: short glitch rejected
    curReq = "R1 glitch";
    rxLine = 1'b0;
    repeat (16) @(negedge clk);
    rxLine = 1'b1;
    repeat (200) @(negedge clk);
    curReq = "R1 after glitch";
    sendFrame(8'h5A, 0, 0, 1, 1);
    pulse(0);

    // R10: configuration changed mid-frame
    curReq = "R10 scramble";
    sendFrame(8'hC6, 1, 0, 1, 1);
    pulse(0);

    repeat (20) @(negedge clk);
    finishRun();
  end

endmodule